// File: doc/BRIEF.md
# Performance Counter CSR Bank

This block keeps the machine-mode performance counts of a small in-order core. It holds a free-running 64-bit clock-cycle count, a 64-bit count of retired instructions, and up to eight event counters. Each event counter has a fixed event input from the pipeline and a width set by a parameter. Software reaches all of them through a single-cycle CSR port. The port carries an enable, a 12-bit address, a 2-bit operation and 32 bits of write data. Read data and an illegal-address flag return combinationally in the same cycle.

Each counter can be stopped on its own through a counter-inhibit register. The event selectors are read-only. Each one shows the event its counter is bound to, as a one-hot value. When software writes a counter, the whole 64-bit value is split into a low register and a high register, each 32 bits wide. Writing one half leaves the other half unchanged. Counters that are not built and bits beyond the configured width read as zero.

Top module: `hpm_csr_bank`

## Requirements
- R1: After reset every counter reads 0 and the inhibit register (0x320) reads 0, so every built counter is enabled.
- R2: The cycle counter is 64 bits wide. Its low half is at 0xB00 and its high half at 0xB80. It adds 1 on every clock edge while inhibit bit 0 is 0, and a carry out of the low half reaches the high half.
- R3: The retired-instruction counter is 64 bits wide, at 0xB02 (low) and 0xB82 (high). It adds 1 on each edge where `instr_retired` is 1 and inhibit bit 2 is 0.
- R4: Event counter N sits at 0xB00+N (low) and 0xB80+N (high). It exists for N from 3 to 2+min(NUM_EVT,8); a NUM_EVT above 8 adds no further counter. It adds 1 on each edge where `evt_hit[N-3]` is 1, which carries event ID N.
- R5: Event counters are CNT_W bits wide and wrap modulo 2^CNT_W. High-half bits above the configured width read 0.
- R6: `csr_op` is 00 read, 01 write, 10 set bits (OR) and 11 clear bits (AND-NOT). Read data always shows the value before the access. A write, set or clear to a counter changes only the addressed 32-bit half.
- R7: A write, set or clear to a counter overrides that counter's increment in the same cycle.
- R8: Inhibit bits 0, 2 and 3..2+min(NUM_EVT,8) can be written; every other inhibit bit reads 0. A new inhibit value first takes effect on the edge after the access. A counter whose bit is 1 holds its value.
- R9: Selector N (0x320+N, N from 3 to 31) reads 1<<N when counter N exists and 0 otherwise. Writes to the selectors are ignored.
- R10: A counter that is not built reads 0 at both halves, ignores writes and ignores its event input.
- R11: With `csr_en` set, any address outside 0xB00, 0xB02..0xB1F, 0xB80, 0xB82..0xB9F, 0x320 and 0x323..0x33F raises `csr_illegal` in the same cycle. Such an access returns zero data and changes no state. With `csr_en` low, both outputs are 0.
- R12: Reading a counter never changes its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_en | input | 1 | CSR access valid this cycle |
| csr_op | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write data / bit mask |
| instr_retired | input | 1 | One instruction retired this cycle |
| evt_hit | input | 8 | Event pulses; bit k is event ID k+3 |
| csr_rdata | output | 32 | Read data (value before the access) |
| csr_illegal | output | 1 | Access to an unrecognised address |

## Verification
The counters are driven with several kinds of input. Free-running cycles show that the inhibit register gates counting, and a low half primed to all ones shows the carry into the high half. Bursts of retirement pulses are sent with the inhibit bit both clear and set. Event inputs with mixed masks show that each counter is bound to its own event. A counter is written while its event input is held high, which shows that the write wins over the increment. A counter primed just below the top of its range shows wrap and truncation at a width other than 32. A pulse on the input of a counter that is not built, together with illegal addresses, tells a correctly ignored access apart from one that leaks into the state. A second instance with the counter count above eight checks the clamp.

// File: rtl/hpm_pkg.sv
`timescale 1ns/1ps
// Package: shared types, address pages and the read-modify-write helper for
// the performance counter bank. Assumes 12-bit CSR addresses.
package hpm_pkg;

    typedef enum logic [1:0] {
        CSR_READ  = 2'b00,
        CSR_WRITE = 2'b01,
        CSR_SET   = 2'b10,
        CSR_CLEAR = 2'b11
    } csr_op_e;

    localparam int          EVT_INPUTS   = 8;   // event IDs 3..10
    localparam int          EVT_MAX      = 8;   // most event counters built
    localparam int          SLOT_COUNT   = 32;  // counter slots 0..31
    localparam logic [6:0]  PAGE_CNT_LO  = 7'b1011000;  // 0xB00..0xB1F
    localparam logic [6:0]  PAGE_CNT_HI  = 7'b1011100;  // 0xB80..0xB9F
    localparam logic [6:0]  PAGE_CFG     = 7'b0011001;  // 0x320..0x33F

    // Combine the old 32-bit word with write data according to the operation.
    function automatic logic [31:0] apply_op(csr_op_e op, logic [31:0] old_w,
                                             logic [31:0] wd);
        logic [31:0] res;
        unique case (op)
            CSR_WRITE: res = wd;
            CSR_SET:   res = old_w | wd;
            CSR_CLEAR: res = old_w & ~wd;
            default:   res = old_w;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/hpm_addr_decode.sv
`timescale 1ns/1ps
// Address decoder: classifies a CSR address into counter-low, counter-high,
// inhibit or selector space and extracts the slot index. Purely combinational.
// Assumes slot 1 (0xB01/0xB81/0x321) and config slots 1..2 are not mapped.
module hpm_addr_decode
    import hpm_pkg::*;
(
    input  logic [11:0] addr,
    output logic        hit_lo,
    output logic        hit_hi,
    output logic        hit_inh,
    output logic        hit_sel,
    output logic        legal,
    output logic [4:0]  idx
);

    logic [6:0] page;

    // Split the address into page and slot index.
    always_comb begin
        page = addr[11:5];
        idx  = addr[4:0];
    end

    // Match each address region.
    always_comb begin
        hit_lo  = (page == PAGE_CNT_LO) && (idx != 5'd1);
        hit_hi  = (page == PAGE_CNT_HI) && (idx != 5'd1);
        hit_inh = (page == PAGE_CFG)    && (idx == 5'd0);
        hit_sel = (page == PAGE_CFG)    && (idx >= 5'd3);
        legal   = hit_lo | hit_hi | hit_inh | hit_sel;
    end

endmodule

// File: rtl/hpm_counter.sv
`timescale 1ns/1ps
// Counter: a W-bit counter seen by software as a 64-bit value split in two
// 32-bit halves. A CSR update of either half wins over the increment.
// Assumes 1 <= W <= 64; bits above W read as zero.
module hpm_counter
    import hpm_pkg::*;
#(
    parameter int W = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inc,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  csr_op_e     op,
    input  logic [31:0] wdata,
    output logic [63:0] val
);

    logic [W-1:0] cnt_q;
    logic [63:0]  nxt64;
    logic         unused_nxt;

    // Zero-extend the stored count to the 64-bit software view.
    always_comb begin
        val          = '0;
        val[W-1:0]   = cnt_q;
    end

    // Build the post-write value with only the addressed half modified.
    always_comb begin
        nxt64 = val;
        if (wr_lo) nxt64[31:0]  = apply_op(op, val[31:0],  wdata);
        if (wr_hi) nxt64[63:32] = apply_op(op, val[63:32], wdata);
    end

    assign unused_nxt = ^nxt64;

    // Update the count: reset, then CSR update, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (wr_lo || wr_hi) cnt_q <= nxt64[W-1:0];
        else if (inc)            cnt_q <= cnt_q + W'(1);
    end

endmodule

// File: rtl/hpm_inhibit.sv
`timescale 1ns/1ps
// Inhibit register: one stop bit per counter slot. Only bits set in MASK are
// storage; all others are tied to zero. Resets to all-enabled.
module hpm_inhibit
    import hpm_pkg::*;
#(
    parameter logic [31:0] MASK = 32'h5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  csr_op_e     op,
    input  logic [31:0] wdata,
    output logic [31:0] inh
);

    // Hold the inhibit bits, updating the writable ones on a CSR access.
    always_ff @(posedge clk) begin
        if (!rst_n)  inh <= '0;
        else if (wr) inh <= apply_op(op, inh, wdata) & MASK;
    end

endmodule

// File: rtl/hpm_csr_bank.sv
`timescale 1ns/1ps
// Performance counter CSR bank: cycle counter (slot 0), retired-instruction
// counter (slot 2) and up to eight event counters (slots 3..10) bound one to
// one to event inputs. Decodes a single-cycle CSR port with combinational
// read data. Assumes the caller issues at most one CSR access per cycle.
module hpm_csr_bank
    import hpm_pkg::*;
#(
    parameter int NUM_EVT = 0,
    parameter int CNT_W   = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_en,
    input  logic [1:0]  csr_op,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    input  logic        instr_retired,
    input  logic [EVT_INPUTS-1:0] evt_hit,
    output logic [31:0] csr_rdata,
    output logic        csr_illegal
);

    localparam int NUM_IMPL  = (NUM_EVT > EVT_MAX) ? EVT_MAX : NUM_EVT;
    localparam int LAST_SLOT = 2 + NUM_IMPL;

    // Writable inhibit bits: cycle, retired, and each built event counter.
    function automatic logic [31:0] inh_mask_f(int last);
        logic [31:0] m;
        m    = '0;
        m[0] = 1'b1;
        m[2] = 1'b1;
        for (int i = 3; i < SLOT_COUNT; i++) begin
            if (i <= last) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [31:0] INH_MASK = inh_mask_f(LAST_SLOT);

    csr_op_e                     op_e;
    logic                        hit_lo, hit_hi, hit_inh, hit_sel, legal;
    logic [4:0]                  idx;
    logic                        wr_any;
    logic [31:0]                 inh_q;
    logic [SLOT_COUNT-1:0][63:0] slot_val;
    logic [SLOT_COUNT-1:0]       wr_lo_v, wr_hi_v;
    logic                        unused_evt;

    assign op_e       = csr_op_e'(csr_op);
    assign unused_evt = ^evt_hit;

    hpm_addr_decode u_dec (
        .addr    (csr_addr),
        .hit_lo  (hit_lo),
        .hit_hi  (hit_hi),
        .hit_inh (hit_inh),
        .hit_sel (hit_sel),
        .legal   (legal),
        .idx     (idx)
    );

    // A modifying access to a recognised address.
    assign wr_any = csr_en && legal && (op_e != CSR_READ);

    // Per-slot write strobes for the two counter halves.
    always_comb begin
        for (int s = 0; s < SLOT_COUNT; s++) begin
            wr_lo_v[s] = wr_any && hit_lo && (idx == 5'(s));
            wr_hi_v[s] = wr_any && hit_hi && (idx == 5'(s));
        end
    end

    hpm_inhibit #(.MASK(INH_MASK)) u_inh (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_any && hit_inh),
        .op    (op_e),
        .wdata (csr_wdata),
        .inh   (inh_q)
    );

    hpm_counter #(.W(64)) u_cycle (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (!inh_q[0]),
        .wr_lo (wr_lo_v[0]),
        .wr_hi (wr_hi_v[0]),
        .op    (op_e),
        .wdata (csr_wdata),
        .val   (slot_val[0])
    );

    assign slot_val[1] = '0;

    hpm_counter #(.W(64)) u_retired (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (instr_retired && !inh_q[2]),
        .wr_lo (wr_lo_v[2]),
        .wr_hi (wr_hi_v[2]),
        .op    (op_e),
        .wdata (csr_wdata),
        .val   (slot_val[2])
    );

    // Event counters: built for slots 3..LAST_SLOT, zero elsewhere.
    for (genvar s = 3; s < SLOT_COUNT; s++) begin : g_evt
        if (s <= LAST_SLOT) begin : g_on
            hpm_counter #(.W(CNT_W)) u_evt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (evt_hit[s-3] && !inh_q[s]),
                .wr_lo (wr_lo_v[s]),
                .wr_hi (wr_hi_v[s]),
                .op    (op_e),
                .wdata (csr_wdata),
                .val   (slot_val[s])
            );
        end else begin : g_off
            assign slot_val[s] = '0;
        end
    end

    // Read mux: old value of the addressed register, zero when idle or illegal.
    always_comb begin
        csr_rdata = '0;
        if (csr_en) begin
            if (hit_lo)       csr_rdata = slot_val[idx][31:0];
            else if (hit_hi)  csr_rdata = slot_val[idx][63:32];
            else if (hit_inh) csr_rdata = inh_q;
            else if (hit_sel && (int'(idx) <= LAST_SLOT))
                              csr_rdata = 32'd1 << idx;
        end
    end

    // Illegal-access flag for unrecognised addresses.
    assign csr_illegal = csr_en && !legal;

endmodule

// File: rtl/hpm_csr_bank_chk.sv
`timescale 1ns/1ps
// Checker for hpm_csr_bank: temporal properties on the CSR port, the inhibit
// register and the two fixed 64-bit counters. Attached by bind below.
module hpm_csr_bank_chk #(
    parameter int NUM_EVT = 0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_en,
    input logic [1:0]  csr_op,
    input logic [11:0] csr_addr,
    input logic [31:0] csr_wdata,
    input logic [31:0] csr_rdata,
    input logic        csr_illegal,
    input logic        instr_retired,
    input logic [31:0] inh_q,
    input logic [63:0] cyc_val,
    input logic [63:0] ret_val
);

    localparam int N_BUILT = (NUM_EVT > 8) ? 8 : NUM_EVT;

    logic [31:0] exp_mask;
    logic        cyc_wr, ret_wr, inh_wr;

    always_comb begin
        exp_mask = 32'h5;
        for (int i = 0; i < N_BUILT; i++) exp_mask[3+i] = 1'b1;
    end

    assign cyc_wr = csr_en && (csr_op != 2'b00) &&
                    (csr_addr == 12'hB00 || csr_addr == 12'hB80);
    assign ret_wr = csr_en && (csr_op != 2'b00) &&
                    (csr_addr == 12'hB02 || csr_addr == 12'hB82);
    assign inh_wr = csr_en && (csr_op == 2'b01) && (csr_addr == 12'h320);

    a_r11_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == 32'h0));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_en |-> (!csr_illegal && csr_rdata == 32'h0));

    a_r2_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!inh_q[0] && !cyc_wr) |=> (cyc_val == $past(cyc_val) + 64'd1));

    a_r8_cycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_q[0] && !cyc_wr) |=> $stable(cyc_val));

    a_r3_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_retired && !inh_q[2] && !ret_wr) |=> (ret_val == $past(ret_val) + 64'd1));

    a_r8_inhibit_write: assert property (@(posedge clk) disable iff (!rst_n)
        inh_wr |=> (inh_q == ($past(csr_wdata) & exp_mask)));

    a_r9_selector_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && csr_addr == 12'h323) |-> (csr_rdata == ((N_BUILT >= 1) ? 32'h8 : 32'h0)));

endmodule

bind hpm_csr_bank hpm_csr_bank_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_en        (csr_en),
    .csr_op        (csr_op),
    .csr_addr      (csr_addr),
    .csr_wdata     (csr_wdata),
    .csr_rdata     (csr_rdata),
    .csr_illegal   (csr_illegal),
    .instr_retired (instr_retired),
    .inh_q         (inh_q),
    .cyc_val       (slot_val[0]),
    .ret_val       (slot_val[2])
);

// File: tb/test_hpm_csr_bank.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected read data and illegal flag
// for each access; a monitor at the falling edge pops and compares.
module test_hpm_csr_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_en = 1'b0;
    logic [1:0]  csr_op = 2'b00;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic        instr_retired = 1'b0;
    logic [7:0]  evt_hit = '0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;

    // Second instance: more counters requested than can be built.
    logic [11:0] w_addr = '0;
    logic [31:0] w_rdata;
    logic        w_illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        logic [31:0] rdata;
        logic        ill;
        bit          chk_data;
        string       tag;
    } exp_t;
    exp_t q_exp[$];

    always #2.5 clk = ~clk;

    hpm_csr_bank #(.NUM_EVT(4), .CNT_W(36)) i_hpm_csr_bank (
        .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_op(csr_op),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .instr_retired(instr_retired), .evt_hit(evt_hit),
        .csr_rdata(csr_rdata), .csr_illegal(csr_illegal)
    );

    hpm_csr_bank #(.NUM_EVT(12), .CNT_W(64)) i_hpm_csr_bank_wide (
        .clk(clk), .rst_n(rst_n), .csr_en(1'b1), .csr_op(2'b00),
        .csr_addr(w_addr), .csr_wdata(32'h0),
        .instr_retired(1'b0), .evt_hit(8'h0),
        .csr_rdata(w_rdata), .csr_illegal(w_illegal)
    );

    // One CSR access in the next cycle; queue its expected outcome.
    task automatic access(input logic [1:0] op, input logic [11:0] addr,
                          input logic [31:0] wd, input logic [31:0] exp_rd,
                          input logic exp_ill, input string tag,
                          input bit chk_data = 1);
        exp_t e;
        @(posedge clk); #1;
        csr_en = 1'b1; csr_op = op; csr_addr = addr; csr_wdata = wd;
        e.rdata = exp_rd; e.ill = exp_ill; e.chk_data = chk_data; e.tag = tag;
        q_exp.push_back(e);
    endtask

    // Hold event / retire inputs high for n edges with the port idle.
    task automatic pulse(input logic [7:0] mask, input logic ret, input int n);
        @(posedge clk); #1;
        csr_en = 1'b0; evt_hit = mask; instr_retired = ret;
        repeat (n) @(posedge clk);
        #1; evt_hit = '0; instr_retired = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; csr_en = 1'b0; end
    endtask

    // Monitor: compare every access against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && csr_en) begin
            if (q_exp.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL unexpected access addr=%h (no expectation queued)", csr_addr);
            end else begin
                exp_t e;
                e = q_exp.pop_front();
                n_cmp++;
                if ((e.chk_data && csr_rdata !== e.rdata) || csr_illegal !== e.ill) begin
                    n_bad++;
                    $display("FAIL %s addr=%h: rdata=%h ill=%b expected rdata=%h ill=%b",
                             e.tag, csr_addr, csr_rdata, csr_illegal, e.rdata, e.ill);
                end
            end
        end
    end

    // Direct combinational read check on the wide instance.
    task automatic wide_read(input logic [11:0] addr, input logic [31:0] exp_rd,
                             input string tag);
        @(posedge clk); #1; w_addr = addr;
        @(negedge clk);
        n_cmp++;
        if (w_rdata !== exp_rd || w_illegal !== 1'b0) begin
            n_bad++;
            $display("FAIL %s addr=%h: rdata=%h ill=%b expected rdata=%h ill=0",
                     tag, addr, w_rdata, w_illegal, exp_rd);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    localparam logic [1:0] RD = 2'b00, WR = 2'b01, ST = 2'b10, CL = 2'b11;

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        access(RD, 12'h320, 0, 32'h0, 0, "R1 inhibit after reset");
        access(RD, 12'hB02, 0, 32'h0, 0, "R1 retired lo after reset");
        access(RD, 12'hB82, 0, 32'h0, 0, "R1 retired hi after reset");
        access(RD, 12'hB03, 0, 32'h0, 0, "R1 event3 after reset");
        access(RD, 12'hB86, 0, 32'h0, 0, "R1 event6 hi after reset");
        access(RD, 12'hB80, 0, 32'h0, 0, "R1 cycle hi after reset");

        // R2 cycle counter under inhibit control
        access(WR, 12'h320, 32'h1, 32'h0, 0, "R8 inhibit write");
        access(WR, 12'hB00, 32'd100, 32'h0, 0, "R2 cycle preset", 0);
        access(RD, 12'hB00, 0, 32'd100, 0, "R8 cycle held while inhibited");
        access(CL, 12'h320, 32'h1, 32'h1, 0, "R8 clear inhibit bit0");
        access(RD, 12'hB00, 0, 32'd100, 0, "R8 new inhibit acts one edge later");
        access(RD, 12'hB00, 0, 32'd101, 0, "R2 cycle +1");
        access(RD, 12'hB00, 0, 32'd102, 0, "R2 cycle +2");
        access(ST, 12'h320, 32'h1, 32'h0, 0, "R6 set inhibit bit0");
        access(RD, 12'hB00, 0, 32'd104, 0, "R2 cycle stopped");
        access(RD, 12'hB00, 0, 32'd104, 0, "R12 repeated read stable");
        access(WR, 12'hB00, 32'hFFFF_FFFF, 32'd104, 0, "R6 cycle lo write");
        access(WR, 12'hB80, 32'h0, 32'h0, 0, "R6 cycle hi write");
        access(CL, 12'h320, 32'h1, 32'h1, 0, "R8 release cycle");
        access(RD, 12'hB80, 0, 32'h0, 0, "R2 hi before carry");
        access(RD, 12'hB80, 0, 32'h1, 0, "R2 carry into hi");
        access(ST, 12'h320, 32'h1, 32'h0, 0, "R8 stop cycle");
        access(RD, 12'hB00, 0, 32'h2, 0, "R2 lo after carry");

        // R3 retired instructions
        pulse(8'h00, 1'b1, 5);
        access(RD, 12'hB02, 0, 32'd5, 0, "R3 five retirements");
        access(ST, 12'h320, 32'h4, 32'h1, 0, "R8 inhibit retired");
        pulse(8'h00, 1'b1, 3);
        access(RD, 12'hB02, 0, 32'd5, 0, "R8 retired held");
        access(CL, 12'h320, 32'h4, 32'h5, 0, "R8 release retired");

        // R4 event binding
        pulse(8'h0B, 1'b0, 2);
        pulse(8'h01, 1'b0, 1);
        pulse(8'h10, 1'b0, 5);
        access(RD, 12'hB04, 0, 32'd2, 0, "R4 event4 count");
        access(RD, 12'hB05, 0, 32'd0, 0, "R4 event5 untouched");
        access(RD, 12'hB06, 0, 32'd2, 0, "R4 event6 count");
        access(RD, 12'hB07, 0, 32'd0, 0, "R10 unbuilt counter ignores event");
        access(RD, 12'hB87, 0, 32'd0, 0, "R10 unbuilt counter hi");

        // R7 write beats increment
        access(RD, 12'hB03, 0, 32'd3, 0, "R4 event3 count");
        evt_hit = 8'h01;
        access(WR, 12'hB03, 32'd50, 32'd4, 0, "R7 pre-write value");
        access(RD, 12'hB03, 0, 32'd50, 0, "R7 write wins over increment");
        access(RD, 12'hB03, 0, 32'd51, 0, "R7 counting resumes");
        evt_hit = 8'h00;
        access(RD, 12'hB03, 0, 32'd51, 0, "R12 read stable");

        // R8 inhibit mask and event hold
        access(WR, 12'h320, 32'hFFFF_FFFF, 32'h1, 0, "R8 write all ones");
        access(RD, 12'h320, 0, 32'h7D, 0, "R8 only built bits stick");
        pulse(8'hFF, 1'b0, 3);
        access(RD, 12'hB03, 0, 32'd51, 0, "R8 event3 held");
        access(RD, 12'hB06, 0, 32'd2, 0, "R8 event6 held");
        access(WR, 12'h320, 32'h1, 32'h7D, 0, "R8 release events");

        // R6 operations on one half only
        access(WR, 12'hB05, 32'h0F0F_0000, 32'h0, 0, "R6 write");
        access(ST, 12'hB05, 32'h0000_00FF, 32'h0F0F_0000, 0, "R6 set");
        access(CL, 12'hB05, 32'h0F00_0000, 32'h0F0F_00FF, 0, "R6 clear");
        access(RD, 12'hB05, 0, 32'h000F_00FF, 0, "R6 result");
        access(RD, 12'hB85, 0, 32'h0, 0, "R6 hi untouched");
        access(WR, 12'hB85, 32'h3, 32'h0, 0, "R6 hi write");
        access(RD, 12'hB05, 0, 32'h000F_00FF, 0, "R6 lo untouched");
        access(RD, 12'hB85, 0, 32'h3, 0, "R6 hi result");

        // R5 width truncation and wrap
        access(WR, 12'hB04, 32'hFFFF_FFFF, 32'd2, 0, "R5 lo preset");
        access(WR, 12'hB84, 32'hFFFF_FFFF, 32'h0, 0, "R5 hi preset");
        access(RD, 12'hB84, 0, 32'hF, 0, "R5 hi truncated to width");
        pulse(8'h02, 1'b0, 1);
        access(RD, 12'hB04, 0, 32'h0, 0, "R5 wrap lo");
        access(RD, 12'hB84, 0, 32'h0, 0, "R5 wrap hi");

        // R9 selectors
        access(RD, 12'h323, 0, 32'h8, 0, "R9 selector3");
        access(RD, 12'h326, 0, 32'h40, 0, "R9 selector6");
        access(RD, 12'h327, 0, 32'h0, 0, "R9 unbuilt selector");
        access(RD, 12'h33F, 0, 32'h0, 0, "R9 top selector");
        access(WR, 12'h323, 32'h0, 32'h8, 0, "R9 write");
        access(RD, 12'h323, 0, 32'h8, 0, "R9 write ignored");

        // R10 unbuilt counters ignore writes
        access(WR, 12'hB07, 32'h1234, 32'h0, 0, "R10 write unbuilt");
        access(RD, 12'hB07, 0, 32'h0, 0, "R10 still zero");
        access(WR, 12'hB1F, 32'h5, 32'h0, 0, "R10 write slot31");
        access(RD, 12'hB1F, 0, 32'h0, 0, "R10 slot31 zero");

        // R11 illegal addresses
        access(RD, 12'h321, 0, 32'h0, 1, "R11 0x321");
        access(RD, 12'hB01, 0, 32'h0, 1, "R11 0xB01");
        access(RD, 12'hB81, 0, 32'h0, 1, "R11 0xB81");
        access(RD, 12'h7C0, 0, 32'h0, 1, "R11 0x7C0");
        access(WR, 12'h322, 32'hFF, 32'h0, 1, "R11 write 0x322");
        access(ST, 12'hB45, 32'hFFFF_FFFF, 32'h0, 1, "R11 set 0xB45");
        access(RD, 12'h320, 0, 32'h1, 0, "R11 inhibit unchanged");
        access(RD, 12'hB05, 0, 32'h000F_00FF, 0, "R11 counter unchanged");
        idle(2);

        // R4 clamp on the wide instance (counters 3..10 only)
        wide_read(12'h32A, 32'h400, "R4 clamp selector10 built");
        wide_read(12'h32B, 32'h0, "R4 clamp selector11 absent");
        wide_read(12'h320, 32'h0, "R1 wide inhibit reset");

        idle(2);
        if (q_exp.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL %0d expectations never observed", q_exp.size());
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule